// File: doc/BRIEF.md
# Sine-Modulated PWM Sample Sequencer

This block sets the compare value of an external PWM generator so that the duty cycle follows a sine wave. A low-pass filter after the PWM pin then turns that duty cycle into an analog sine. The block holds a one-cycle sine table as a ROM that it computes at elaboration. The table has 128 positive 7-bit codes centred on 64. The block also keeps a table pointer. On each PWM period boundary the pointer moves forward by a programmable step. It wraps modulo the table length, and the addressed code goes into the compare register for the next pulse.

The step sets the output frequency. A step of 8 picks every eighth sample, so one sine cycle takes 16 PWM periods. With a 510-clock PWM period at 8 MHz this gives a sine of about 980.4 Hz. Larger steps raise the frequency and give fewer samples per cycle. The PWM counter and the analog filter are outside this block.

Top module: `sinepwm_seq`

## Requirements
- R1: While `rstN` is low and after it is released, the table pointer is 0 and `compareOut` is 64, which is the code at index 0.
- R2: Table entry i is round(64 + 63·sin(2πi/128)) for i in 0..127. `compareOut` always carries an entry in bits [6:0] with bit 7 zero, so every value lies between 1 and 127. For example, index 32 gives 127, index 64 gives 64 and index 96 gives 1.
- R3: An advance event is a cycle in which `enable` is high and `overflowPulse` is high after being low in the cycle before. On each advance event the pointer becomes (pointer + `stepSize`) mod 128. `compareOut` becomes the table entry at that new pointer.
- R4: `compareOut` changes only at the clock edge that ends an advance-event cycle, so the new value is visible in the following cycle. In every other cycle it holds.
- R5: `stepSize` is used only in the advance-event cycle. Changes to it between events have no effect until the next event.
- R6: While `enable` is low, overflow pulses are ignored and the pointer and `compareOut` keep their values.
- R7: If `overflowPulse` stays high for several cycles, that counts as one event only.
- R8: With a step of 8, the output sequence repeats every 16 events.
- R9: With a step of 0, events leave `compareOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Sequencer enable; low freezes the pointer and the output |
| overflowPulse | input | 1 | PWM period-boundary strobe from the PWM counter |
| stepSize | input | 7 | Pointer increment per period (0 to 127) |
| compareOut | output | 8 | Compare value sent to the PWM generator |

## Verification
The assertions take the overflow strobe to be a plain level that the block itself turns into events. They take a step sampled at the event edge to be the one that counts. They also take the table to be the only source of output codes, so any code outside 1..127 is an error. The stimulus drives every input at the falling clock edge. It mixes random enable, step and strobe patterns with strobes held high for several cycles and steps changed between events. A reference pointer in the bench follows the same event rule.

// File: rtl/sinepwm_pkg.sv
package sinepwm_pkg;

  typedef struct packed {
    logic advance;     // move pointer by step this cycle
    logic loadSample;  // capture addressed table code into compare register
  } seqStrobe_t;

  // Offset sine code: mid + (mid-1)*sin(2*pi*idx/depth), rounded to nearest.
  function automatic int sineCode(input int idx, input int depth, input int sampW);
    real mid;
    real amp;
    real ang;
    mid = real'(2 ** (sampW - 1));
    amp = mid - 1.0;
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(depth);
    return $rtoi(mid + amp * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/sinepwm_rom.sv
module sinepwm_rom #(
  parameter int DEPTH  = 128,
  parameter int SAMP_W = 7,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]  addr,
  output logic [SAMP_W-1:0] code
);

  logic [SAMP_W-1:0] romTable [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int CODE_VAL = sinepwm_pkg::sineCode(i, DEPTH, SAMP_W);
    assign romTable[i] = SAMP_W'(CODE_VAL);
  end

  assign code = romTable[addr];

endmodule

// File: rtl/sinepwm_ctrl.sv
module sinepwm_ctrl (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    overflowPulse,
  output sinepwm_pkg::seqStrobe_t strobe
);

  logic ovfPrevQ;
  logic riseSeen;

  always_ff @(posedge clk) begin
    if (!rstN) ovfPrevQ <= 1'b0;
    else       ovfPrevQ <= overflowPulse;
  end

  // A strobe held high produces one event only.
  assign riseSeen          = overflowPulse & ~ovfPrevQ;
  assign strobe.advance    = riseSeen & enable;
  assign strobe.loadSample = riseSeen & enable;

endmodule

// File: rtl/sinepwm_dp.sv
module sinepwm_dp #(
  parameter int DEPTH  = 128,
  parameter int SAMP_W = 7,
  parameter int OUT_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sinepwm_pkg::seqStrobe_t strobe,
  input  logic [IDX_W-1:0]        stepSize,
  output logic [IDX_W-1:0]        pointer,
  output logic [OUT_W-1:0]        compareOut
);

  localparam int RESET_CODE = sinepwm_pkg::sineCode(0, DEPTH, SAMP_W);

  logic [IDX_W-1:0]  pointerQ;
  logic [IDX_W-1:0]  pointerNext;
  logic [SAMP_W-1:0] sampleCode;
  logic [OUT_W-1:0]  compareQ;

  // Power-of-two depth: natural adder overflow is the modulo wrap.
  assign pointerNext = pointerQ + stepSize;

  sinepwm_rom #(.DEPTH(DEPTH), .SAMP_W(SAMP_W)) u_rom (
    .addr(pointerNext),
    .code(sampleCode)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pointerQ <= '0;
    end else if (strobe.advance) begin
      pointerQ <= pointerNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      compareQ <= OUT_W'(RESET_CODE);
    end else if (strobe.loadSample) begin
      compareQ <= OUT_W'(sampleCode);
    end
  end

  assign pointer    = pointerQ;
  assign compareOut = compareQ;

endmodule

// File: rtl/sinepwm_seq.sv
module sinepwm_seq #(
  parameter int TABLE_DEPTH = 128,
  parameter int SAMP_W      = 7,
  parameter int OUT_W       = 8,
  localparam int IDX_W      = $clog2(TABLE_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             overflowPulse,
  input  logic [IDX_W-1:0] stepSize,
  output logic [OUT_W-1:0] compareOut
);

  sinepwm_pkg::seqStrobe_t strobe;
  logic [IDX_W-1:0]        pointerQ;

  sinepwm_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .enable(enable),
    .overflowPulse(overflowPulse),
    .strobe(strobe)
  );

  sinepwm_dp #(.DEPTH(TABLE_DEPTH), .SAMP_W(SAMP_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .stepSize(stepSize),
    .pointer(pointerQ),
    .compareOut(compareOut)
  );

endmodule

// File: rtl/sinepwm_seq_checker.sv
module sinepwm_seq_checker #(
  parameter int IDX_W  = 7,
  parameter int SAMP_W = 7,
  parameter int OUT_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             overflowPulse,
  input logic [IDX_W-1:0] stepSize,
  input logic [IDX_W-1:0] pointerQ,
  input logic [OUT_W-1:0] compareOut
);

  logic chkPrevOvf;
  logic chkEvent;

  always_ff @(posedge clk) begin
    if (!rstN) chkPrevOvf <= 1'b0;
    else       chkPrevOvf <= overflowPulse;
  end

  assign chkEvent = enable && overflowPulse && !chkPrevOvf;

  p_code_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (compareOut < OUT_W'(2 ** SAMP_W)) && (compareOut != '0));

  p_ptr_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    chkEvent |=> pointerQ == IDX_W'($past(pointerQ) + $past(stepSize)));

  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !chkEvent |=> $stable(compareOut) && $stable(pointerQ));

  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(compareOut));

  p_held_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (overflowPulse && chkPrevOvf) |=> $stable(pointerQ));

  p_zero_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (chkEvent && stepSize == '0) |=> $stable(compareOut));

endmodule

bind sinepwm_seq sinepwm_seq_checker #(.IDX_W(IDX_W), .SAMP_W(SAMP_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .enable(enable),
  .overflowPulse(overflowPulse),
  .stepSize(stepSize),
  .pointerQ(pointerQ),
  .compareOut(compareOut)
);

// File: tb/sinepwm_seq_bench.sv
module sinepwm_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       overflowPulse = 1'b0;
  logic [6:0] stepSize = 7'd8;
  logic [7:0] compareOut;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  logic [6:0] mPtr = '0;
  logic       mPrev = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sinepwm_seq u_sinepwm_seq (
    .clk(clk),
    .rstN(rstN),
    .enable(enable),
    .overflowPulse(overflowPulse),
    .stepSize(stepSize),
    .compareOut(compareOut)
  );

  function automatic logic [7:0] expSine(input int idx);
    real v;
    v = 64.0 + 63.0 * $sin(2.0 * 3.14159265358979 * real'(idx) / 128.0);
    return 8'($rtoi(v + 0.5));
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: compareOut=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge, update the model, then sample after the rising edge.
  task automatic cyc(input logic ovf, input logic en, input logic [6:0] stp, input string tag);
    @(negedge clk);
    overflowPulse = ovf;
    enable        = en;
    stepSize      = stp;
    if (ovf && !mPrev && en) mPtr = mPtr + stp;
    mPrev = ovf;
    @(posedge clk);
    #1;
    check(compareOut, expSine(int'(mPtr)), tag);
  endtask

  task automatic pulse(input logic [6:0] stp, input string tag);
    cyc(1'b1, 1'b1, stp, tag);
    cyc(1'b0, 1'b1, stp, tag);
  endtask

  initial begin
    logic [7:0] startVal;
    void'($urandom(32'd2024));

    // R1 reset state
    repeat (3) @(negedge clk);
    check(compareOut, 8'd64, "R1 during reset");
    rstN = 1'b1;
    @(posedge clk); #1;
    check(compareOut, 8'd64, "R1 after reset");

    // R2 table corners with step 32: indices 32, 64, 96, 0
    pulse(7'd32, "R2 idx32");
    check(compareOut, 8'd127, "R2 peak");
    pulse(7'd32, "R2 idx64");
    check(compareOut, 8'd64, "R2 middle");
    pulse(7'd32, "R2 idx96");
    check(compareOut, 8'd1, "R2 trough");
    pulse(7'd32, "R3 wrap to 0");
    check(compareOut, 8'd64, "R3 wrap");

    // R4 the output changes only in the cycle after the event
    @(negedge clk);
    overflowPulse = 1'b1; stepSize = 7'd8; enable = 1'b1;
    #1;
    check(compareOut, 8'd64, "R4 not before edge");
    mPtr = mPtr + 7'd8; mPrev = 1'b1;
    @(posedge clk); #1;
    check(compareOut, expSine(int'(mPtr)), "R4 after edge");
    cyc(1'b0, 1'b1, 7'd8, "R4 hold");

    // R8 step 8 repeats every 16 events
    startVal = compareOut;
    for (int k = 0; k < 16; k++) pulse(7'd8, "R8 sweep");
    check(compareOut, startVal, "R8 period 16");

    // R7 strobe held high counts once
    cyc(1'b1, 1'b1, 7'd5, "R7 rise");
    for (int k = 0; k < 5; k++) cyc(1'b1, 1'b1, 7'd5, "R7 held");
    cyc(1'b0, 1'b1, 7'd5, "R7 release");

    // R5 step changes between events are ignored
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, 7'($urandom_range(1, 127)), "R5 idle step change");
    pulse(7'd3, "R5 step at event");

    // R6 disabled pulses ignored
    for (int k = 0; k < 6; k++) cyc(k[0] ? 1'b0 : 1'b1, 1'b0, 7'd17, "R6 disabled");
    // R6 strobe rising while disabled and held into enable gives no event
    cyc(1'b1, 1'b0, 7'd9, "R6 rise disabled");
    cyc(1'b1, 1'b1, 7'd9, "R6 held into enable");
    cyc(1'b0, 1'b1, 7'd9, "R6 release");

    // R9 zero step
    startVal = compareOut;
    pulse(7'd0, "R9 zero step");
    check(compareOut, startVal, "R9 unchanged");

    // Random mix
    for (int k = 0; k < 1500; k++) begin
      logic       rOvf;
      logic       rEn;
      logic [6:0] rStp;
      rOvf = ($urandom_range(0, 99) < 35);
      rEn  = ($urandom_range(0, 99) < 85);
      rStp = ($urandom_range(0, 3) == 0) ? 7'd8 : 7'($urandom_range(0, 127));
      cyc(rOvf, rEn, rStp, "R3 random");
    end

    // R1 reset again mid-run
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    check(compareOut, 8'd64, "R1 re-reset");
    mPtr = '0; mPrev = 1'b0;
    @(negedge clk); rstN = 1'b1; overflowPulse = 1'b0;
    pulse(7'd8, "R1 restart from 0");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule